// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This combinational unit looks at one 32-bit single-precision operand and reports what kind of value it is. It returns a class code, the sign and a flag that says whether a NaN signals. It also builds the quieted form of a signaling NaN and raises an invalid-operation flag when it does so. Any other operand passes through to the quiet output without change.

A mode input selects between two opposite NaN conventions. In the newer (2008) convention, a set top fraction bit marks a quiet NaN. In the legacy convention, a set top fraction bit marks a signaling NaN. In legacy mode, quieting clears the top fraction bit. If that leaves the fraction at zero, the operand would read as an infinity, so the next fraction bit is set to keep it a NaN.

A floating-point datapath uses the unit wherever operands must be screened before arithmetic. It is also used when a NaN must be handed on as a result. Exponent and fraction widths are parameters, and the defaults give the 8/23 single-precision format.

Top module: `fp_nan_classify_quiet`

## Requirements
- R1: For a non-NaN operand, cls_o gives 3'd0 for zero (exponent 0, fraction 0), 3'd1 for denormal (exponent 0, fraction nonzero), 3'd2 for normal (exponent neither 0 nor all ones) and 3'd3 for infinity (exponent all ones, fraction 0). Exponent is bits 30:23 and fraction is bits 22:0.
- R2: An operand with exponent all ones and a nonzero fraction is a NaN, and cls_o is 3'd4 (quiet) or 3'd5 (signaling).
- R3: For a NaN, snan_o equals nan2008_i XOR bit 22. snan_o is low for every non-NaN, and cls_o is 3'd5 exactly when snan_o is high.
- R4: With nan2008_i high, a signaling NaN gives quiet_o equal to op_i with bit 22 set and every other bit kept.
- R5: With nan2008_i low, a signaling NaN gives quiet_o equal to op_i with bit 22 cleared. If bits 21:0 are then all zero, bit 21 is also set.
- R6: invalid_o is high exactly when the operand is a signaling NaN.
- R7: When the operand is not a signaling NaN, quiet_o equals op_i and invalid_o is low, whatever the mode.
- R8: sign_o equals bit 31 of op_i for every class, and quieting never alters bit 31.
- R9: For a signaling input, quiet_o is always a NaN that reads as quiet under the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 32 | Operand |
| nan2008_i | input | 1 | 1: set top fraction bit means quiet; 0: legacy, set means signaling |
| cls_o | output | 3 | Class code |
| sign_o | output | 1 | Operand sign |
| snan_o | output | 1 | Operand is a signaling NaN |
| quiet_o | output | 32 | Quieted NaN, or operand unchanged |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The assertions are evaluated on every input change. They cover the following properties:
- invalid_o agrees with snan_o.
- A non-signaling operand passes through unchanged.
- The sign is preserved.
- Class 5 matches the signaling flag.
- Every quieted result is a NaN that is quiet under the same mode.
- In 2008 mode, quieting only sets bit 22.

Only the bench scenarios can show that the class codes are right for each operand kind and that the legacy guard sets bit 21 for exactly the right fraction. They also show that the two modes treat the same bit pattern in opposite ways.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } fp_cls_e;
endpackage

// File: rtl/fp_field_split.sv
module fp_field_split #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      op_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              exp_ones_o,
  output logic              exp_zero_o,
  output logic              frac_zero_o,
  output logic              frac_msb_o
);
  always_comb begin
    sign_o      = op_i[W-1];
    exp_o       = op_i[W-2:FRAC_W];
    frac_o      = op_i[FRAC_W-1:0];
    exp_ones_o  = &exp_o;
    exp_zero_o  = ~|exp_o;
    frac_zero_o = ~|frac_o;
    frac_msb_o  = frac_o[FRAC_W-1];
  end
endmodule

// File: rtl/fp_classify.sv
module fp_classify
  import fp_nan_pkg::*;
(
  input  logic    exp_ones_i,
  input  logic    exp_zero_i,
  input  logic    frac_zero_i,
  input  logic    frac_msb_i,
  input  logic    nan2008_i,
  output fp_cls_e cls_o,
  output logic    is_nan_o,
  output logic    snan_o
);
  always_comb begin
    is_nan_o = exp_ones_i & ~frac_zero_i;
    // 2008: msb clear signals; legacy: msb set signals
    snan_o   = is_nan_o & (nan2008_i ^ frac_msb_i);
    unique case ({exp_ones_i, exp_zero_i})
      2'b01:   cls_o = frac_zero_i ? CLS_ZERO : CLS_DENORM;
      2'b10:   cls_o = frac_zero_i ? CLS_INF : (snan_o ? CLS_SNAN : CLS_QNAN);
      default: cls_o = CLS_NORMAL;
    endcase
  end
endmodule

// File: rtl/fp_nan_quiet.sv
module fp_nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  input  logic         nan2008_i,
  input  logic         snan_i,
  output logic [W-1:0] quiet_o,
  output logic         invalid_o
);
  localparam int QB = FRAC_W - 1;
  localparam int GB = FRAC_W - 2;

  logic [W-1:0] q2008, qleg, qleg_clr;

  always_comb begin
    q2008     = op_i;
    q2008[QB] = 1'b1;
    qleg_clr     = op_i;
    qleg_clr[QB] = 1'b0;
    qleg         = qleg_clr;
    // keep it a NaN instead of collapsing to infinity
    if (~|qleg_clr[FRAC_W-1:0]) qleg[GB] = 1'b1;
    if (snan_i) quiet_o = nan2008_i ? q2008 : qleg;
    else        quiet_o = op_i;
    invalid_o = snan_i;
  end
endmodule

// File: rtl/fp_nan_classify_quiet.sv
module fp_nan_classify_quiet
  import fp_nan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  input  logic         nan2008_i,
  output logic [2:0]   cls_o,
  output logic         sign_o,
  output logic         snan_o,
  output logic [W-1:0] quiet_o,
  output logic         invalid_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  logic exp_ones, exp_zero, frac_zero, frac_msb, is_nan;
  fp_cls_e cls_w;

  fp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
    .op_i        (op_i),
    .sign_o      (sign_o),
    .exp_o       (exp_w),
    .frac_o      (frac_w),
    .exp_ones_o  (exp_ones),
    .exp_zero_o  (exp_zero),
    .frac_zero_o (frac_zero),
    .frac_msb_o  (frac_msb)
  );

  fp_classify u_cls (
    .exp_ones_i  (exp_ones),
    .exp_zero_i  (exp_zero),
    .frac_zero_i (frac_zero),
    .frac_msb_i  (frac_msb),
    .nan2008_i   (nan2008_i),
    .cls_o       (cls_w),
    .is_nan_o    (is_nan),
    .snan_o      (snan_o)
  );

  fp_nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .op_i      (op_i),
    .nan2008_i (nan2008_i),
    .snan_i    (snan_o),
    .quiet_o   (quiet_o),
    .invalid_o (invalid_o)
  );

  assign cls_o = cls_w;

  logic unused_w;
  assign unused_w = ^{exp_w, frac_w, is_nan};
endmodule

// File: rtl/fp_nan_classify_quiet_chk.sv
module fp_nan_classify_quiet_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic [W-1:0] op_i,
  input logic         nan2008_i,
  input logic [2:0]   cls_o,
  input logic         sign_o,
  input logic         snan_o,
  input logic [W-1:0] quiet_o,
  input logic         invalid_o
);
  localparam int QB = FRAC_W - 1;

  always_comb begin
    assert_invalid_match_R6: assert (invalid_o == snan_o);
    assert_snan_class_R3: assert (snan_o == (cls_o == 3'd5));
    assert_sign_kept_R8: assert ((sign_o == op_i[W-1]) && (quiet_o[W-1] == op_i[W-1]));
    if (!snan_o) begin
      assert_pass_through_R7: assert (quiet_o == op_i && !invalid_o);
    end
    if (snan_o) begin
      assert_quiet_is_nan_R9: assert ((&quiet_o[W-2:FRAC_W]) && (|quiet_o[FRAC_W-1:0])
                                      && ((nan2008_i ^ quiet_o[QB]) == 1'b0));
    end
    if (snan_o && nan2008_i) begin
      assert_set_qbit_R4: assert (quiet_o == (op_i | (W'(1) << QB)));
    end
  end
endmodule

bind fp_nan_classify_quiet fp_nan_classify_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_i      (op_i),
  .nan2008_i (nan2008_i),
  .cls_o     (cls_o),
  .sign_o    (sign_o),
  .snan_o    (snan_o),
  .quiet_o   (quiet_o),
  .invalid_o (invalid_o)
);

// File: tb/tb_fp_nan_classify_quiet.sv
`timescale 1ns/1ps
module tb_fp_nan_classify_quiet;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op_i = '0;
  logic        nan2008_i = 1'b1;
  logic [2:0]  cls_o;
  logic        sign_o, snan_o, invalid_o;
  logic [31:0] quiet_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_nan_classify_quiet dut (
    .op_i(op_i), .nan2008_i(nan2008_i), .cls_o(cls_o), .sign_o(sign_o),
    .snan_o(snan_o), .quiet_o(quiet_o), .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] v, input logic m);
    @(negedge clk);
    op_i = v;
    nan2008_i = m;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_all(input string req, input logic [2:0] c, input logic s,
                            input logic sn, input logic [31:0] q, input logic inv);
    chk({req, " cls"}, {29'd0, cls_o}, {29'd0, c});
    chk("R8 sign", {31'd0, sign_o}, {31'd0, s});
    chk({req, " snan"}, {31'd0, snan_o}, {31'd0, sn});
    chk({req, " quiet"}, quiet_o, q);
    chk("R6 invalid", {31'd0, invalid_o}, {31'd0, inv});
  endtask

  task automatic t_reset_state;
    apply(32'h0000_0000, 1'b1);
    expect_all("R1 reset zero", 3'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_plain_classes;
    apply(32'h8000_0000, 1'b1); expect_all("R1 negzero", 3'd0, 1'b1, 1'b0, 32'h8000_0000, 1'b0);
    apply(32'h0000_0001, 1'b1); expect_all("R1 denorm", 3'd1, 1'b0, 1'b0, 32'h0000_0001, 1'b0);
    apply(32'hBF80_0000, 1'b0); expect_all("R1 normal", 3'd2, 1'b1, 1'b0, 32'hBF80_0000, 1'b0);
    apply(32'h7F7F_FFFF, 1'b1); expect_all("R1 maxnorm", 3'd2, 1'b0, 1'b0, 32'h7F7F_FFFF, 1'b0);
    apply(32'hFF80_0000, 1'b1); expect_all("R1 neginf", 3'd3, 1'b1, 1'b0, 32'hFF80_0000, 1'b0);
    // R7 infinity under legacy mode is not touched
    apply(32'h7F80_0000, 1'b0); expect_all("R7 inf legacy", 3'd3, 1'b0, 1'b0, 32'h7F80_0000, 1'b0);
  endtask

  task automatic t_nan_2008;
    apply(32'h7FC0_0000, 1'b1); expect_all("R2 R7 qnan2008", 3'd4, 1'b0, 1'b0, 32'h7FC0_0000, 1'b0);
    apply(32'h7F80_0001, 1'b1); expect_all("R4 snan2008", 3'd5, 1'b0, 1'b1, 32'h7FC0_0001, 1'b1);
    apply(32'hFFA0_0000, 1'b1); expect_all("R4 R8 negsnan", 3'd5, 1'b1, 1'b1, 32'hFFE0_0000, 1'b1);
  endtask

  task automatic t_nan_legacy;
    apply(32'h7FC0_0005, 1'b0); expect_all("R5 snanleg", 3'd5, 1'b0, 1'b1, 32'h7F80_0005, 1'b1);
    apply(32'h7F80_0001, 1'b0); expect_all("R3 R7 qnanleg", 3'd4, 1'b0, 1'b0, 32'h7F80_0001, 1'b0);
    apply(32'h7FA0_0000, 1'b0); expect_all("R7 qnanleg2", 3'd4, 1'b0, 1'b0, 32'h7FA0_0000, 1'b0);
  endtask

  task automatic t_legacy_guard;
    apply(32'h7FC0_0000, 1'b0); expect_all("R5 R9 guard", 3'd5, 1'b0, 1'b1, 32'h7FA0_0000, 1'b1);
    apply(32'hFFC0_0000, 1'b0); expect_all("R5 R9 negguard", 3'd5, 1'b1, 1'b1, 32'hFFA0_0000, 1'b1);
    apply(32'h7FE0_0000, 1'b0); expect_all("R5 noguard", 3'd5, 1'b0, 1'b1, 32'h7FA0_0000, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_plain_classes();
    t_nan_2008();
    t_nan_legacy();
    t_legacy_guard();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule